// File: doc/BRIEF.md
# Ethernet PHY Status Indicator Controller

This block drives the five status indicators of a 10/100 Ethernet physical layer. Its inputs are the line state of the layer: link good, selected speed, duplex mode, transmit activity, receive activity and collision. From these it produces two speed indicators and an activity indicator. It also produces a link indicator that carries activity and an indicator shared by full duplex and collision. Detecting those conditions is done elsewhere. This block only decides what each indicator shows.

A single prescaler divides the system clock, whose frequency is a parameter, into a tick at four times the activity blink rate. A two-bit phase counter advances on that tick. Its bits give a 10 Hz square wave for activity and a 20 Hz square wave for collision. Short activity and collision events are held busy by tick-counting stretchers, so that a one-cycle event still produces a visible blink. Every indicator is registered. Each one responds one clock after its inputs change.

Top module: `eth_led_ctrl`

## Requirements
- R1: While `rst` is high, all five indicators are driven low one clock later, and the prescaler, phase and stretch state are cleared.
- R2: `led_spd10` is high exactly when `spd_100` was low on the previous clock, whatever the link state.
- R3: `led_spd100` is high exactly when `spd_100` was high on the previous clock, whatever the link state.
- R4: With the link up, receive activity and no collision, `led_act` blinks at the activity rate: it is high for CLK_HZ/20 cycles and low for CLK_HZ/20 cycles. Transmit activity alone leaves it dark.
- R5: With the link up and neither transmit nor receive activity, `led_link` is steadily high. While either kind of activity is present, it blinks at the activity rate.
- R6: With the link up and no collision, `led_dupcol` is steadily high when `full_dup` is 1 and dark when it is 0.
- R7: A collision while the link is up makes `led_dupcol` blink at the collision rate (CLK_HZ/40 cycles high, CLK_HZ/40 low). This overrides the full-duplex level. Any collision also forces `led_act` dark on the next clock.
- R8: When `link_up` is low, `led_act`, `led_link` and `led_dupcol` are dark on the next clock, whatever the other inputs are.
- R9: One event of a single cycle keeps its blink going for at least one full blink period afterwards. For receive or transmit activity on `led_link` that is CLK_HZ/10 cycles. For a collision on `led_dupcol` it is CLK_HZ/20 cycles. The indicator then returns to its steady level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Link good |
| spd_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| col | input | 1 | Collision present |
| led_spd10 | output | 1 | 10 Mbps speed indicator |
| led_spd100 | output | 1 | 100 Mbps speed indicator |
| led_act | output | 1 | Receive activity indicator |
| led_link | output | 1 | Link indicator, blinking on activity |
| led_dupcol | output | 1 | Full duplex level or collision blink |

## Verification
Two functions can compete for the same indicator in the same cycle. The steady full-duplex level and the collision blink both drive `led_dupcol`. Receive blinking and collision suppression both drive `led_act`.

The bench provokes each overlap by holding `full_dup`, `rx_act` and `col` high together. It then judges the outcome by counting high samples and transitions over an 80-cycle window:
- a 20 Hz pattern on the shared indicator means collision won;
- a dark activity indicator means the suppression took effect.

Single-cycle pulses of `rx_act` and `col`, each on a steady background, show that the stretched blink appears first and the steady level returns afterwards.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    // Status inputs gathered into one record
    typedef struct packed {
        logic link_up;
        logic spd_100;
        logic full_dup;
        logic tx_act;
        logic rx_act;
        logic col;
    } phy_status_t;

    // Indicator outputs gathered into one record
    typedef struct packed {
        logic spd10;
        logic spd100;
        logic act;
        logic link;
        logic dupcol;
    } led_vec_t;

    // Stretch sources, one stretcher each
    typedef enum logic [1:0] {
        SRC_RX  = 2'd0,
        SRC_TRX = 2'd1,
        SRC_COL = 2'd2
    } stretch_src_e;

    localparam int NUM_STRETCH = 3;

    // One tick is a quarter of the activity period.
    // Activity period = 4 ticks, collision period = 2 ticks.
    // One extra tick is loaded so that at least a full period stays visible.
    function automatic int stretch_ticks(input int idx);
        if (idx == int'(SRC_COL)) return 3;
        return 5;
    endfunction

    function automatic led_vec_t compose(
        input phy_status_t s,
        input logic        rx_busy,
        input logic        trx_busy,
        input logic        col_busy,
        input logic        wave_slow,
        input logic        wave_fast
    );
        led_vec_t v;
        v.spd10  = ~s.spd_100;
        v.spd100 =  s.spd_100;
        v.act    = s.link_up & rx_busy & ~col_busy & wave_slow;
        v.link   = s.link_up & (trx_busy ? wave_slow : 1'b1);
        v.dupcol = s.link_up & (col_busy ? wave_fast : s.full_dup);
        return v;
    endfunction

endpackage

// File: rtl/eth_led_prescaler.sv
module eth_led_prescaler #(
    parameter int CLK_HZ = 25_000_000,
    parameter int ACT_HZ = 10
) (
    input  logic       clk,
    input  logic       rst,
    output logic       tick,
    output logic [1:0] phase
);
    localparam int TICK_CYC = (CLK_HZ / (4 * ACT_HZ)) > 0 ? CLK_HZ / (4 * ACT_HZ) : 1;
    localparam int CW       = TICK_CYC > 1 ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 2'b00;
        end else if (tick) begin
            cnt   <= '0;
            phase <= phase + 2'b01;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/eth_led_stretch.sv
module eth_led_stretch #(
    parameter int LOAD_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic evt,
    output logic busy
);
    localparam int SW = $clog2(LOAD_TICKS + 1);
    localparam logic [SW-1:0] LOAD = SW'(LOAD_TICKS);

    logic [SW-1:0] remain;

    assign busy = evt | (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (evt) begin
            remain <= LOAD;
        end else if (tick && remain != '0) begin
            remain <= remain - SW'(1);
        end
    end
endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
    import eth_led_pkg::*;
#(
    parameter int CLK_HZ = 25_000_000,
    parameter int ACT_HZ = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic spd_100,
    input  logic full_dup,
    input  logic tx_act,
    input  logic rx_act,
    input  logic col,
    output logic led_spd10,
    output logic led_spd100,
    output logic led_act,
    output logic led_link,
    output logic led_dupcol
);
    phy_status_t             st;
    logic                    tick;
    logic [1:0]              phase;
    logic [NUM_STRETCH-1:0]  evt;
    logic [NUM_STRETCH-1:0]  busy;
    led_vec_t                next_led;
    led_vec_t                led_q;

    assign st = '{link_up: link_up, spd_100: spd_100, full_dup: full_dup,
                  tx_act: tx_act, rx_act: rx_act, col: col};

    assign evt[SRC_RX]  = st.rx_act;
    assign evt[SRC_TRX] = st.rx_act | st.tx_act;
    assign evt[SRC_COL] = st.col;

    eth_led_prescaler #(.CLK_HZ(CLK_HZ), .ACT_HZ(ACT_HZ)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (phase)
    );

    for (genvar i = 0; i < NUM_STRETCH; i++) begin : g_str
        eth_led_stretch #(.LOAD_TICKS(stretch_ticks(i))) u_str (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .evt  (evt[i]),
            .busy (busy[i])
        );
    end

    // The slow wave is phase bit 1 (2 ticks per half period).
    // The fast wave is phase bit 0 (1 tick per half period).
    always_comb begin
        next_led = compose(st, busy[SRC_RX], busy[SRC_TRX], busy[SRC_COL],
                           ~phase[1], ~phase[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= '0;
        else     led_q <= next_led;
    end

    assign led_spd10  = led_q.spd10;
    assign led_spd100 = led_q.spd100;
    assign led_act    = led_q.act;
    assign led_link   = led_q.link;
    assign led_dupcol = led_q.dupcol;
endmodule

// File: rtl/eth_led_ctrl_chk.sv
module eth_led_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic link_up,
    input logic spd_100,
    input logic col,
    input logic led_spd10,
    input logic led_spd100,
    input logic led_act,
    input logic led_link,
    input logic led_dupcol
);
    // R1
    reset_dark_chk: assert property (@(posedge clk)
        rst |=> !(led_spd10 || led_spd100 || led_act || led_link || led_dupcol));

    // R2
    spd10_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (led_spd10 == !$past(spd_100)));

    // R3
    spd100_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (led_spd100 == $past(spd_100)));

    // R8
    link_down_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(link_up)) |-> !(led_act || led_link || led_dupcol));

    // R7
    col_mutes_act_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(col)) |-> !led_act);
endmodule

bind eth_led_ctrl eth_led_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .spd_100    (spd_100),
    .col        (col),
    .led_spd10  (led_spd10),
    .led_spd100 (led_spd100),
    .led_act    (led_act),
    .led_link   (led_link),
    .led_dupcol (led_dupcol)
);

// File: tb/eth_led_ctrl_test.sv
`timescale 1ns/1ps
module eth_led_ctrl_test;
    localparam int CLK_HZ = 400;   // one tick = 10 cycles
    localparam int ACT_HZ = 10;
    localparam int WIN    = 80;

    // Indicator modes: 0 off, 1 on, 2 slow blink, 3 fast blink
    // Vector layout: {link,spd100,dup,tx,rx,col, spd10,spd100,act,link,dupcol modes}
    localparam logic [15:0] VEC [9] = '{
        {6'b100000, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0},  // R2 R5 R6 half duplex idle
        {6'b111000, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1},  // R3 R6 full duplex idle
        {6'b110010, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0},  // R4 R5 receive
        {6'b100100, 2'd1, 2'd0, 2'd0, 2'd2, 2'd0},  // R4 R5 transmit only
        {6'b111001, 2'd0, 2'd1, 2'd0, 2'd1, 2'd3},  // R7 collision over full duplex
        {6'b100011, 2'd1, 2'd0, 2'd0, 2'd2, 2'd3},  // R7 receive with collision
        {6'b011111, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0},  // R8 link down, all busy
        {6'b000010, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0},  // R8 R2 link down at 10
        {6'b111110, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1}   // R4 R5 R6 full duplex traffic
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 0, spd_100 = 0, full_dup = 0, tx_act = 0, rx_act = 0, col = 0;
    logic led_spd10, led_spd100, led_act, led_link, led_dupcol;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    eth_led_ctrl #(.CLK_HZ(CLK_HZ), .ACT_HZ(ACT_HZ)) uut (
        .clk(clk), .rst(rst), .link_up(link_up), .spd_100(spd_100),
        .full_dup(full_dup), .tx_act(tx_act), .rx_act(rx_act), .col(col),
        .led_spd10(led_spd10), .led_spd100(led_spd100), .led_act(led_act),
        .led_link(led_link), .led_dupcol(led_dupcol)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] s);
        {link_up, spd_100, full_dup, tx_act, rx_act, col} = s;
    endtask

    function automatic logic pick(input int idx);
        case (idx)
            0: return led_spd10;
            1: return led_spd100;
            2: return led_act;
            3: return led_link;
            default: return led_dupcol;
        endcase
    endfunction

    // Observe WIN negedge samples of every indicator and classify each one
    task automatic observe(output int mode [5]);
        int ons [5];
        int trans [5];
        logic prev [5];
        for (int k = 0; k < 5; k++) begin ons[k] = 0; trans[k] = 0; end
        for (int n = 0; n < WIN; n++) begin
            @(negedge clk);
            for (int k = 0; k < 5; k++) begin
                logic v;
                v = pick(k);
                if (v) ons[k]++;
                if (n > 0 && v != prev[k]) trans[k]++;
                prev[k] = v;
            end
        end
        for (int k = 0; k < 5; k++) begin
            if (ons[k] == 0 && trans[k] == 0)            mode[k] = 0;
            else if (ons[k] == WIN && trans[k] == 0)     mode[k] = 1;
            else if (ons[k] == WIN/2 && trans[k] >= 3 && trans[k] <= 4) mode[k] = 2;
            else if (ons[k] == WIN/2 && trans[k] >= 7 && trans[k] <= 8) mode[k] = 3;
            else                                          mode[k] = 7;
        end
    endtask

    initial begin
        int m [5];
        int offs;
        // R1: outputs dark under reset with active inputs
        drive(6'b111111);
        repeat (4) @(negedge clk);
        check("R1 reset dark", {led_spd10, led_spd100, led_act, led_link, led_dupcol}, 0);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < 9; v++) begin
            drive(VEC[v][15:10]);
            repeat (100) @(negedge clk);
            observe(m);
            check($sformatf("R2 spd10 vec%0d", v),   m[0], int'(VEC[v][9:8]));
            check($sformatf("R3 spd100 vec%0d", v),  m[1], int'(VEC[v][7:6]));
            check($sformatf("R4 act vec%0d", v),     m[2], int'(VEC[v][5:4]));
            check($sformatf("R5 link vec%0d", v),    m[3], int'(VEC[v][3:2]));
            check($sformatf("R6 R7 dupcol vec%0d", v), m[4], int'(VEC[v][1:0]));
        end

        // R9: single-cycle receive pulse stretched on led_link
        drive(6'b110000);
        repeat (100) @(negedge clk);
        rx_act = 1'b1;
        @(negedge clk);
        rx_act = 1'b0;
        offs = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (!led_link) offs++;
        end
        check("R9 rx pulse blinks link", offs > 0, 1);
        repeat (40) @(negedge clk);
        observe(m);
        check("R9 link back to steady", m[3], 1);

        // R9: single-cycle collision pulse stretched on led_dupcol, full duplex
        drive(6'b111000);
        repeat (100) @(negedge clk);
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
        offs = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (!led_dupcol) offs++;
        end
        check("R9 col pulse blinks dupcol", offs > 0, 1);
        repeat (40) @(negedge clk);
        observe(m);
        check("R9 dupcol back to steady", m[4], 1);

        // R1: reset in mid-run, one clock to dark
        drive(6'b111110);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset dark",
              {led_spd10, led_spd100, led_act, led_link, led_dupcol}, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule